// File: doc/BRIEF.md
# Video Port Command Decoder

This block sits between a 16-bit host bus and the memories of a video processor. It owns two host-visible ports: a control port and a data port. Control writes either program one of the processor's 8-bit registers in a single word, or deliver a command in two words. The two words together build a 6-bit access code and a 16-bit target address. Data-port writes are then steered to one of three memories: a word-wide video RAM, a 40-entry scroll RAM of 10-bit words, or a 64-entry colour RAM of 9-bit words. After each accepted write the address moves on by a programmable step.

The memories live next to the block. The decoder drives their shared write port: three one-cycle write pulses, an index and a repacked data word. Register writes are forwarded on a strobe/number/value port to the rest of the processor. Two registers are also used locally: the mode register that holds the DMA enable bit, and the step register. A control-port read returns a fixed status pattern with a live DMA-busy bit. Byte accesses are widened to words before they are decoded.

Top module: `vpc_port_decoder`

## Requirements
- R1: A control write with no command pending whose bits 15..14 are not binary 10 sets the pending flag, loads command bits 1..0 from data bits 15..14 and loads address bits 13..0 from data bits 13..0. All other command and address bits keep their value.
- R2: A control write while a command is pending clears the flag, loads command bits 5..2 from data bits 7..4 and loads address bits 15..14 from data bits 1..0. All other command and address bits keep their value. The top bits of the word are not examined.
- R3: A control write with no command pending whose bits 15..14 are binary 10 is a register write. It pulses `reg_we` with `reg_num` = data bits 12..8 and `reg_val` = data bits 7..0. Bit 13 has no effect, and the command, the address and the pending flag are unchanged.
- R4: A control-port read, a data-port read and a data-port write each clear the pending flag.
- R5: A control-port read returns 0x3400 OR'd with `dma_busy` in bit 1. A data-port read returns 0x0000.
- R6: A data write is steered by command bits 3..0: 1 selects video RAM, 5 selects scroll RAM and 3 selects colour RAM. Any other code makes no write pulse and leaves the address unchanged. At most one write pulse is high in any cycle.
- R7: A video RAM write uses address bits 15..1 as the index. It stores the word as given when address bit 0 is 0, and with its two bytes exchanged when address bit 0 is 1.
- R8: A scroll RAM write uses address bits 6..1 as the index and stores data bits 9..0 (upper bits zero). When the index is 40 or more, the write is dropped and the address does not advance.
- R9: A colour RAM write uses address bits 6..1 as the index and stores the 9-bit value {data[11:9], data[7:5], data[3:1]}.
- R10: After each accepted data write, the address advances modulo 2^16 by the 8-bit value last written to register 15. This step is 0 after reset.
- R11: A byte access (`bus_byte` = 1) to either port acts as a word access whose two bytes both equal `bus_wdata[7:0]`.
- R12: A write to register 1 with bit 4 (DMA enable) clear forces command bit 5 to 0. With bit 4 set, the command is unchanged.
- R13: After reset, the pending flag, the command, the address and the step are zero, and no write or register pulse is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe; ignored when `bus_wr` is high |
| bus_ctrl | input | 1 | 1 = control port, 0 = data port |
| bus_byte | input | 1 | Byte access; low byte is mirrored |
| bus_wdata | input | 16 | Write data |
| dma_busy | input | 1 | DMA activity shown in status bit 1 |
| bus_rdata | output | 16 | Read data, registered on each read |
| cmd_pending | output | 1 | First command word has been taken |
| cmd_code | output | 6 | Current access code |
| cur_addr | output | 16 | Current access address |
| reg_we | output | 1 | Register write pulse |
| reg_num | output | 5 | Register number |
| reg_val | output | 8 | Register value |
| wr_vram | output | 1 | Video RAM write pulse |
| wr_scroll | output | 1 | Scroll RAM write pulse |
| wr_color | output | 1 | Colour RAM write pulse |
| wr_index | output | 15 | Memory word index |
| wr_data | output | 16 | Repacked memory data |

## Verification
Every result of this block is registered. It appears in the cycle after the edge that takes the bus strobe: the pending flag, the command and the address, the register pulse, the memory write pulse with its index and data, and the read data. The address increment lands in that same cycle and uses the step held before the access. The bench drives each access on a falling edge, lets one rising edge take it, and compares all outputs on the next falling edge against its own model. It then drops the strobes at that same falling edge, so every pulse is checked to last exactly one cycle.

// File: rtl/vpc_pkg.sv
package vpc_pkg;

  localparam int WORD_W = 16;
  localparam int CMD_W  = 6;
  localparam int STEP_W = 8;

  typedef enum logic [3:0] {
    TGT_VRAM   = 4'd1,
    TGT_COLOR  = 4'd3,
    TGT_SCROLL = 4'd5
  } tgt_code_e;

  // Mirror the low byte into both halves of a word.
  function automatic logic [WORD_W-1:0] widen_byte(input logic [WORD_W-1:0] w,
                                                   input logic is_byte);
    return is_byte ? {w[7:0], w[7:0]} : w;
  endfunction

  // Exchange the two bytes of a word when the address is odd.
  function automatic logic [WORD_W-1:0] lane_swap(input logic [WORD_W-1:0] w,
                                                  input logic odd);
    return odd ? {w[7:0], w[15:8]} : w;
  endfunction

  // Gather three 3-bit colour fields into one 9-bit word.
  function automatic logic [8:0] pack_color(input logic [WORD_W-1:0] w);
    return {w[11:9], w[7:5], w[3:1]};
  endfunction

  function automatic logic [WORD_W-1:0] step_addr(input logic [WORD_W-1:0] a,
                                                  input logic [STEP_W-1:0] s);
    return a + {{(WORD_W-STEP_W){1'b0}}, s};
  endfunction

endpackage

// File: rtl/vpc_cmd_fsm.sv
module vpc_cmd_fsm
  import vpc_pkg::*;
#(
  parameter int STEP_REG   = 15,
  parameter int MODE_REG   = 1,
  parameter int DMA_EN_BIT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr,
  input  logic              ctrl_rd,
  input  logic              data_acc,
  input  logic              data_adv,
  input  logic [WORD_W-1:0] wword,
  output logic              pending,
  output logic [CMD_W-1:0]  cmd,
  output logic [WORD_W-1:0] addr,
  output logic [STEP_W-1:0] step,
  output logic              reg_we,
  output logic [4:0]        reg_num,
  output logic [7:0]        reg_val
);

  localparam logic [1:0] REG_FORM = 2'b10;

  logic is_reg_form;
  logic first_half;
  logic second_half;

  assign is_reg_form = !pending && (wword[15:14] == REG_FORM);
  assign first_half  = ctrl_wr && !pending && !is_reg_form;
  assign second_half = ctrl_wr && pending;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending <= 1'b0;
      cmd     <= '0;
      addr    <= '0;
      step    <= '0;
      reg_we  <= 1'b0;
      reg_num <= '0;
      reg_val <= '0;
    end else begin
      reg_we <= 1'b0;
      if (second_half) begin
        pending    <= 1'b0;
        cmd[5:2]   <= wword[7:4];
        addr[15:14] <= wword[1:0];
      end else if (first_half) begin
        pending    <= 1'b1;
        cmd[1:0]   <= wword[15:14];
        addr[13:0] <= wword[13:0];
      end else if (ctrl_wr) begin
        reg_we  <= 1'b1;
        reg_num <= wword[12:8];
        reg_val <= wword[7:0];
        if (wword[12:8] == 5'(MODE_REG) && !wword[DMA_EN_BIT]) cmd[5] <= 1'b0;
        if (wword[12:8] == 5'(STEP_REG)) step <= wword[7:0];
      end else if (ctrl_rd || data_acc) begin
        pending <= 1'b0;
        if (data_adv) addr <= step_addr(addr, step);
      end
    end
  end

  assert_first_half_R1: assert property (@(posedge clk) disable iff (!rst_n)
    first_half |=> (pending && cmd[1:0] == $past(wword[15:14])
                    && addr[13:0] == $past(wword[13:0])));

  assert_second_half_R2: assert property (@(posedge clk) disable iff (!rst_n)
    second_half |=> (!pending && cmd[5:2] == $past(wword[7:4])
                     && addr[15:14] == $past(wword[1:0])));

  assert_reg_form_keeps_cmd_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && is_reg_form && wword[12:8] != 5'(MODE_REG)) |=> ($stable(cmd) && $stable(addr) && !pending));

  assert_pending_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_wr && (ctrl_rd || data_acc)) |=> !pending);

  assert_dma_off_clears_cmd5_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && is_reg_form && wword[12:8] == 5'(MODE_REG) && !wword[DMA_EN_BIT]) |=> !cmd[5]);

endmodule

// File: rtl/vpc_data_steer.sv
module vpc_data_steer
  import vpc_pkg::*;
#(
  parameter int SCROLL_DEPTH = 40,
  parameter int SMALL_IDX_W  = 6,
  parameter int SCROLL_W     = 10
) (
  input  logic              data_wr,
  input  logic [CMD_W-1:0]  cmd,
  input  logic [WORD_W-1:0] addr,
  input  logic [WORD_W-1:0] wword,
  output logic              hit_vram,
  output logic              hit_scroll,
  output logic              hit_color,
  output logic              accept,
  output logic [WORD_W-2:0] index,
  output logic [WORD_W-1:0] payload
);

  localparam int IDX_W = WORD_W - 1;

  logic [SMALL_IDX_W-1:0] small_idx;
  logic                   scroll_in_range;

  assign small_idx       = addr[SMALL_IDX_W:1];
  assign scroll_in_range = (int'(small_idx) < SCROLL_DEPTH);

  always_comb begin
    hit_vram   = 1'b0;
    hit_scroll = 1'b0;
    hit_color  = 1'b0;
    index      = '0;
    payload    = '0;
    if (data_wr) begin
      unique case (cmd[3:0])
        TGT_VRAM: begin
          hit_vram = 1'b1;
          index    = addr[WORD_W-1:1];
          payload  = lane_swap(wword, addr[0]);
        end
        TGT_SCROLL: begin
          hit_scroll = scroll_in_range;
          index      = IDX_W'(small_idx);
          payload    = WORD_W'(wword[SCROLL_W-1:0]);
        end
        TGT_COLOR: begin
          hit_color = 1'b1;
          index     = IDX_W'(small_idx);
          payload   = WORD_W'(pack_color(wword));
        end
        default: ;
      endcase
    end
  end

  assign accept = hit_vram | hit_scroll | hit_color;

endmodule

// File: rtl/vpc_port_decoder.sv
module vpc_port_decoder
  import vpc_pkg::*;
#(
  parameter int SCROLL_DEPTH = 40,
  parameter int STEP_REG     = 15,
  parameter int MODE_REG     = 1,
  parameter int DMA_EN_BIT   = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic        bus_ctrl,
  input  logic        bus_byte,
  input  logic [15:0] bus_wdata,
  input  logic        dma_busy,
  output logic [15:0] bus_rdata,
  output logic        cmd_pending,
  output logic [5:0]  cmd_code,
  output logic [15:0] cur_addr,
  output logic        reg_we,
  output logic [4:0]  reg_num,
  output logic [7:0]  reg_val,
  output logic        wr_vram,
  output logic        wr_scroll,
  output logic        wr_color,
  output logic [14:0] wr_index,
  output logic [15:0] wr_data
);

  localparam logic [WORD_W-1:0] STATUS_BASE = 16'h3400;

  logic [WORD_W-1:0] wword;
  logic              ctrl_wr, ctrl_rd, data_wr, data_acc;
  logic              hit_vram, hit_scroll, hit_color, accept;
  logic [WORD_W-2:0] index;
  logic [WORD_W-1:0] payload;
  logic [STEP_W-1:0] step;

  assign wword    = widen_byte(bus_wdata, bus_byte);
  assign ctrl_wr  = bus_wr && bus_ctrl;
  assign ctrl_rd  = bus_rd && !bus_wr && bus_ctrl;
  assign data_wr  = bus_wr && !bus_ctrl;
  assign data_acc = !bus_ctrl && (bus_wr || bus_rd);

  vpc_cmd_fsm #(
    .STEP_REG  (STEP_REG),
    .MODE_REG  (MODE_REG),
    .DMA_EN_BIT(DMA_EN_BIT)
  ) u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctrl_wr (ctrl_wr),
    .ctrl_rd (ctrl_rd),
    .data_acc(data_acc),
    .data_adv(accept),
    .wword   (wword),
    .pending (cmd_pending),
    .cmd     (cmd_code),
    .addr    (cur_addr),
    .step    (step),
    .reg_we  (reg_we),
    .reg_num (reg_num),
    .reg_val (reg_val)
  );

  vpc_data_steer #(
    .SCROLL_DEPTH(SCROLL_DEPTH)
  ) u_steer (
    .data_wr   (data_wr),
    .cmd       (cmd_code),
    .addr      (cur_addr),
    .wword     (wword),
    .hit_vram  (hit_vram),
    .hit_scroll(hit_scroll),
    .hit_color (hit_color),
    .accept    (accept),
    .index     (index),
    .payload   (payload)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_vram   <= 1'b0;
      wr_scroll <= 1'b0;
      wr_color  <= 1'b0;
      wr_index  <= '0;
      wr_data   <= '0;
      bus_rdata <= '0;
    end else begin
      wr_vram   <= hit_vram;
      wr_scroll <= hit_scroll;
      wr_color  <= hit_color;
      if (accept) begin
        wr_index <= index;
        wr_data  <= payload;
      end
      if (ctrl_rd)
        bus_rdata <= STATUS_BASE | {14'b0, dma_busy, 1'b0};
      else if (bus_rd && !bus_wr)
        bus_rdata <= '0;
    end
  end

  assert_status_word_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_rd |=> (bus_rdata[15:2] == 14'h0D00 && bus_rdata[0] == 1'b0));

  assert_single_target_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_vram, wr_scroll, wr_color}));

  assert_scroll_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_scroll |-> (int'(wr_index) < SCROLL_DEPTH));

  assert_addr_advance_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && accept) |=> (cur_addr == WORD_W'($past(cur_addr) + $past(step))));

  assert_no_advance_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && !accept) |=> $stable(cur_addr));

endmodule

// File: tb/vpc_port_decoder_tb.sv
module vpc_port_decoder_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0, bus_ctrl = 1'b0, bus_byte = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic        dma_busy = 1'b0;
  logic [15:0] bus_rdata;
  logic        cmd_pending;
  logic [5:0]  cmd_code;
  logic [15:0] cur_addr;
  logic        reg_we;
  logic [4:0]  reg_num;
  logic [7:0]  reg_val;
  logic        wr_vram, wr_scroll, wr_color;
  logic [14:0] wr_index;
  logic [15:0] wr_data;

  always #2 clk = ~clk;

  vpc_port_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_ctrl(bus_ctrl),
    .bus_byte(bus_byte), .bus_wdata(bus_wdata), .dma_busy(dma_busy),
    .bus_rdata(bus_rdata), .cmd_pending(cmd_pending), .cmd_code(cmd_code),
    .cur_addr(cur_addr), .reg_we(reg_we), .reg_num(reg_num), .reg_val(reg_val),
    .wr_vram(wr_vram), .wr_scroll(wr_scroll), .wr_color(wr_color),
    .wr_index(wr_index), .wr_data(wr_data)
  );

  int n_chk = 0;
  int n_bad = 0;

  // Bench model
  logic        m_pend = 0;
  logic [5:0]  m_cmd = 0;
  logic [15:0] m_addr = 0;
  logic [7:0]  m_step = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] mk_color(input logic [15:0] w);
    logic [15:0] r;
    r = 16'(((w >> 9) & 16'd7) << 6);
    r = r | 16'(((w >> 5) & 16'd7) << 3);
    r = r | ((w >> 1) & 16'd7);
    return r;
  endfunction

  // kind: 0 control write, 1 control read, 2 data write, 3 data read
  task automatic op(input int kind, input logic bmode, input logic [15:0] d, input logic busy);
    logic [15:0] w;
    logic e_rwe, e_v, e_s, e_c;
    logic [4:0] e_num;
    logic [7:0] e_val;
    logic [14:0] e_idx;
    logic [15:0] e_dat, e_rd;
    int i;
    string t;
    w = bmode ? {d[7:0], d[7:0]} : d;
    e_rwe = 0; e_v = 0; e_s = 0; e_c = 0;
    e_num = 0; e_val = 0; e_idx = 0; e_dat = 0; e_rd = 0;
    t = "R4";
    @(negedge clk);
    bus_wr   = (kind == 0 || kind == 2);
    bus_rd   = (kind == 1 || kind == 3);
    bus_ctrl = (kind < 2);
    bus_byte = bmode;
    bus_wdata = d;
    dma_busy = busy;
    if (kind == 0) begin
      if (m_pend) begin
        t = "R2"; m_pend = 0;
        m_cmd = {w[7:4], m_cmd[1:0]};
        m_addr = {w[1:0], m_addr[13:0]};
      end else if (w[15:14] != 2'b10) begin
        t = "R1"; m_pend = 1;
        m_cmd = {m_cmd[5:2], w[15:14]};
        m_addr = {m_addr[15:14], w[13:0]};
      end else begin
        t = "R3"; e_rwe = 1; e_num = w[12:8]; e_val = w[7:0];
        if (w[12:8] == 5'd1 && !w[4]) begin m_cmd[5] = 0; t = "R12"; end
        if (w[12:8] == 5'd15) begin m_step = w[7:0]; t = "R10"; end
      end
    end else if (kind == 1) begin
      m_pend = 0; t = "R5"; e_rd = 16'h3400 + (busy ? 16'd2 : 16'd0);
    end else if (kind == 3) begin
      m_pend = 0; t = "R5";
    end else begin
      m_pend = 0;
      i = int'((m_addr >> 1) & 16'h3F);
      case (m_cmd & 6'hF)
        6'd1: begin
          t = "R7"; e_v = 1; e_idx = 15'(m_addr >> 1);
          e_dat = m_addr[0] ? {w[7:0], w[15:8]} : w;
        end
        6'd5: begin
          t = "R8";
          if (i < 40) begin e_s = 1; e_idx = 15'(i); e_dat = w & 16'h03FF; end
        end
        6'd3: begin
          t = "R9"; e_c = 1; e_idx = 15'(i); e_dat = mk_color(w);
        end
        default: t = "R6";
      endcase
      if (e_v || e_s || e_c) m_addr = m_addr + 16'(m_step);
    end
    if (bmode) t = {t, "/R11"};
    @(negedge clk);
    bus_wr = 0; bus_rd = 0;
    chk({t, " pending"}, 32'(cmd_pending), 32'(m_pend));
    chk({t, " cmd"}, 32'(cmd_code), 32'(m_cmd));
    chk({t, " addr"}, 32'(cur_addr), 32'(m_addr));
    chk({t, " reg_we"}, 32'(reg_we), 32'(e_rwe));
    if (e_rwe) chk({t, " reg"}, {19'b0, reg_num, reg_val}, {19'b0, e_num, e_val});
    chk({t, " R6 pulses"}, {29'b0, wr_vram, wr_scroll, wr_color}, {29'b0, e_v, e_s, e_c});
    if (e_v || e_s || e_c) chk({t, " write"}, {1'b0, wr_index, wr_data}, {1'b0, e_idx, e_dat});
    if (kind == 1 || kind == 3) chk({t, " rdata"}, 32'(bus_rdata), 32'(e_rd));
  endtask

  task automatic set_cmd(input logic [5:0] c, input logic [15:0] a);
    op(0, 0, {c[1:0], a[13:0]}, 0);
    op(0, 0, {8'h00, c[5:2], 2'b00, a[15:14]}, 0);
  endtask

  initial begin
    int seed;
    seed = 32'h5EED;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R13 reset state
    chk("R13 pending", 32'(cmd_pending), 0);
    chk("R13 cmd", 32'(cmd_code), 0);
    chk("R13 addr", 32'(cur_addr), 0);
    chk("R13 pulses", {28'b0, reg_we, wr_vram, wr_scroll, wr_color}, 0);
    // R10 step zero after reset: video write must not move address
    set_cmd(6'h01, 16'h0000);
    op(2, 0, 16'hBEEF, 0);
    // Directed
    op(0, 0, 16'h8F02, 0);              // step = 2
    op(0, 0, 16'hAF04, 0);              // R3 bit13 set, step = 4
    set_cmd(6'h01, 16'h1235);           // odd address, R7 swap
    op(2, 0, 16'hA1B2, 0);
    op(2, 1, 16'h00C7, 0);              // R11 byte widening
    set_cmd(6'h05, 16'h004E);           // scroll idx 39
    op(2, 0, 16'hFFFF, 0);
    op(2, 0, 16'h1234, 0);              // idx 41 dropped, R8
    set_cmd(6'h05, 16'h0050);           // idx 40 dropped
    op(2, 0, 16'h0155, 0);
    set_cmd(6'h03, 16'h007E);           // colour idx 63
    op(2, 0, 16'h0ABE, 0);
    set_cmd(6'h07, 16'h0010);           // unrecognised code, R6
    op(2, 0, 16'h5555, 0);
    set_cmd(6'h21, 16'h0000);
    op(0, 0, 16'h8130, 0);              // R12 enable set, cmd kept
    op(0, 0, 16'h8100, 0);              // R12 enable clear, bit5 cleared
    op(0, 0, 16'h4000, 0);              // pending
    op(1, 0, 16'h0000, 1);              // R4 + R5 busy
    op(0, 0, 16'h4000, 0);
    op(3, 0, 16'h0000, 0);              // R4 data read
    op(0, 0, 16'h0FFF, 0);
    op(1, 0, 16'h0000, 0);              // R5 idle
    op(0, 0, 16'h8FFF, 0);              // step 255, wrap test
    set_cmd(6'h01, 16'hFFF0);
    op(2, 0, 16'h1111, 0);              // R10 wrap
    // Random
    for (int k = 0; k < 1500; k++) begin
      int r;
      logic [15:0] d;
      r = int'($urandom_range(0, 9));
      d = 16'($urandom);
      if (r < 3) begin
        if (!m_pend && r == 0)
          d = {2'b10, d[13], ($urandom_range(0, 1) != 0) ? 5'd15 : 5'd1, d[7:0]};
        else if (!m_pend)
          d = {($urandom_range(0, 1) != 0) ? 2'b01 : 2'b11, d[13:0]};
        else
          d = {d[15:8], 1'b0, ($urandom_range(0, 1) != 0) ? 1'b0 : d[6], d[5:4], d[3:0]};
        op(0, d[0] & d[9] & d[3], d, 0);
      end else if (r < 8) begin
        op(2, ($urandom_range(0, 4) == 0), d, 0);
      end else begin
        op(r == 8 ? 1 : 3, 0, d, d[5]);
      end
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 4);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule